// File: doc/BRIEF.md
# Semaphore-Gated Descriptor Sequencer

This block is one channel of a descriptor-driven DMA engine. It walks a linked list of command descriptors held in memory. Software first loads the address of the first descriptor into the next-descriptor register. It then writes a count into the run counter. While that count is nonzero and the channel is not held, the sequencer does three things in turn: it reads one descriptor through a simple request/acknowledge port, hands the command to the data mover with a one-cycle start pulse, and waits for the mover's done pulse.

Each descriptor carries three flags:
- The link flag names the descriptor that follows.
- The decrement flag makes the command consume one unit of the run count.
- The notify flag raises a completion status that can drive an interrupt.

The channel stops in two cases: when the count reaches zero, or when a command without a link finishes. Software can extend a run that is in progress by adding to the count.

Control is through five registers, each writable through a plain, an OR (set) or an AND-NOT (clear) alias. These registers provide:
- a hold bit that pauses the channel between commands;
- a self-clearing abort bit;
- a completion status with its interrupt enable;
- a second status that records a list ending while count remains;
- the next-descriptor address;
- the run counter.

Top module: `sema_dma_seq`

## Requirements
- R1: After reset the channel is idle, the run count reads 0, the next address reads 0, the hold bit (register 0, bit 8) reads 1, both status bits read 0 and `irq` is low.
- R2: Writing a nonzero value to the run counter (register select 4, plain alias, count in bits 7:0) while not held starts a descriptor fetch at the next address. A zero count never starts a fetch.
- R3: A finished command lowers the run count by one only when its decrement flag (descriptor bit AW+1) is set. The count never goes below zero.
- R4: A plain write to the run counter adds the written value to the current count, including while a run is in progress. The sum saturates at 255. An add and a decrement in the same cycle combine into one net update.
- R5: When a finished command has its link flag (descriptor bit AW) set, its next-address field (descriptor bits AW-1:0) is loaded into the next-address register (select 3). The next fetch comes from that address.
- R6: The channel returns to idle when the run count reaches zero after a command.
- R7: A command with its link flag clear leaves the channel idle even when the count is still nonzero. In that case, if count remains after its own decrement, the status bit of register 2 (bit 0) is set. The channel stays idle until software writes either the run counter or the next-address register.
- R8: While the hold bit is 1, no new descriptor fetch begins. Clearing the hold bit lets a pending run start.
- R9: Writing 1 to the abort bit (register 0, bit 16) returns the channel to idle at once and clears the run count. The bit always reads 0.
- R10: A finished command whose notify flag (descriptor bit AW+2) is set sets the completion status (register 1, bit 0). `irq` is high exactly when that status and its enable (register 1, bit 16) are both 1.
- R11: Write operation codes are 0 for plain (replace), 1 for set (OR in the written bits) and 2 for clear (AND out the written bits). Acknowledging means clearing bit 0 in registers 1 and 2, and it removes both statuses.
- R12: Set and clear writes to the run counter leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 ctrl0, 1 ctrl1, 2 ctrl2, 3 next address, 4 run counter |
| reg_op | input | 2 | Write operation: 0 plain, 1 set, 2 clear |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Descriptor read request, held until acknowledged |
| mem_addr | output | AW (32) | Descriptor address |
| mem_ack | input | 1 | Descriptor read acknowledge, data valid |
| mem_rdata | input | AW+3 (35) | Descriptor: next address, link, decrement, notify |
| xfer_start | output | 1 | One-cycle command start to the data mover |
| xfer_addr | output | AW (32) | Address of the descriptor being executed |
| xfer_done | input | 1 | Command finished pulse from the data mover |
| chan_busy | output | 1 | Channel is fetching or executing |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest state to reach from the ports is a list that ends while count remains. Leaving that state, and the collision of a software add with a hardware decrement, are just as hard. The bench builds descriptor tables in its memory model. It ends a list early with count to spare, then checks that the channel stays idle until a next-address write or a zero-valued count write restarts it. A run is extended by adding to the count while the first command is still in flight with the mover's latency stretched. For the abort test the mover is held so that the reset bit lands mid-command.

// File: rtl/sema_dma_pkg.sv
package sema_dma_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL0 = 3'd0,
    SEL_CTRL1 = 3'd1,
    SEL_CTRL2 = 3'd2,
    SEL_NEXT  = 3'd3,
    SEL_SEMA  = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    OP_BASE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2
  } reg_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2
  } seq_state_e;

  // One register bit updated through a plain, set or clear alias.
  function automatic logic apply_bit(logic [1:0] op, logic cur, logic wbit);
    case (op)
      OP_BASE: return wbit;
      OP_SET:  return cur | wbit;
      OP_CLR:  return cur & ~wbit;
      default: return cur;
    endcase
  endfunction

  function automatic logic [31:0] apply_word(logic [1:0] op, logic [31:0] cur,
                                             logic [31:0] w);
    case (op)
      OP_BASE: return w;
      OP_SET:  return cur | w;
      OP_CLR:  return cur & ~w;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/sema_dma_regs.sv
module sema_dma_regs
  import sema_dma_pkg::*;
#(
  parameter int AW       = 32,
  parameter int SEMA_W   = 8,
  parameter int CH_IDX   = 0,
  parameter int GATE_OFS = 8,
  parameter int RST_OFS  = 16,
  parameter int IEN_OFS  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [1:0]        reg_op,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              hw_cmpl_i,
  input  logic              hw_early_i,
  input  logic              hw_load_i,
  input  logic [AW-1:0]     hw_next_i,
  input  logic [SEMA_W-1:0] count_i,
  output logic              gate_o,
  output logic              abort_o,
  output logic [AW-1:0]     next_addr_o,
  output logic              next_wr_o,
  output logic              inc_en_o,
  output logic [SEMA_W-1:0] inc_val_o,
  output logic              irq_o
);

  localparam int GATE_BIT = GATE_OFS + CH_IDX;
  localparam int RST_BIT  = RST_OFS + CH_IDX;
  localparam int STS_BIT  = CH_IDX;
  localparam int IEN_BIT  = IEN_OFS + CH_IDX;

  logic          gate_q, gate_d;
  logic          sts_q, sts_d;
  logic          ien_q, ien_d;
  logic          early_q, early_d;
  logic [AW-1:0] next_q, next_d;
  logic          wr0, wr1, wr2, wr3;
  logic [31:0]   next_img;

  assign wr0 = reg_wr && (reg_sel == SEL_CTRL0);
  assign wr1 = reg_wr && (reg_sel == SEL_CTRL1);
  assign wr2 = reg_wr && (reg_sel == SEL_CTRL2);
  assign wr3 = reg_wr && (reg_sel == SEL_NEXT);

  always_comb begin
    next_img = '0;
    next_img[AW-1:0] = next_q;
  end

  // Next-state logic; hardware events win over a software clear in the same cycle.
  always_comb begin
    gate_d  = wr0 ? apply_bit(reg_op, gate_q, reg_wdata[GATE_BIT]) : gate_q;
    abort_o = wr0 && apply_bit(reg_op, 1'b0, reg_wdata[RST_BIT]);
    sts_d   = hw_cmpl_i | (wr1 ? apply_bit(reg_op, sts_q, reg_wdata[STS_BIT]) : sts_q);
    ien_d   = wr1 ? apply_bit(reg_op, ien_q, reg_wdata[IEN_BIT]) : ien_q;
    early_d = hw_early_i | (wr2 ? apply_bit(reg_op, early_q, reg_wdata[STS_BIT]) : early_q);
    if (wr3) begin
      next_d = apply_word(reg_op, next_img, reg_wdata);
    end else if (hw_load_i) begin
      next_d = hw_next_i;
    end else begin
      next_d = next_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q  <= 1'b1;
      sts_q   <= 1'b0;
      ien_q   <= 1'b0;
      early_q <= 1'b0;
      next_q  <= '0;
    end else begin
      if (wr0) gate_q <= gate_d;
      if (wr1 || hw_cmpl_i) sts_q <= sts_d;
      if (wr1) ien_q <= ien_d;
      if (wr2 || hw_early_i) early_q <= early_d;
      if (wr3 || hw_load_i) next_q <= next_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CTRL0: reg_rdata[GATE_BIT] = gate_q;
      SEL_CTRL1: begin
        reg_rdata[STS_BIT] = sts_q;
        reg_rdata[IEN_BIT] = ien_q;
      end
      SEL_CTRL2: reg_rdata[STS_BIT] = early_q;
      SEL_NEXT:  reg_rdata[AW-1:0] = next_q;
      SEL_SEMA:  reg_rdata[SEMA_W-1:0] = count_i;
      default:   reg_rdata = '0;
    endcase
  end

  assign gate_o      = gate_q;
  assign next_addr_o = next_q;
  assign next_wr_o   = wr3;
  assign inc_en_o    = reg_wr && (reg_sel == SEL_SEMA) && (reg_op == OP_BASE);
  assign inc_val_o   = reg_wdata[SEMA_W-1:0];
  assign irq_o       = sts_q & ien_q;

  AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hw_cmpl_i |=> sts_q); // R10
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr1 && reg_op == OP_CLR && reg_wdata[STS_BIT] && !hw_cmpl_i) |=> !sts_q); // R11
  AST_ACK_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr2 && reg_op == OP_CLR && reg_wdata[STS_BIT] && !hw_early_i) |=> !early_q); // R11

endmodule

// File: rtl/sema_dma_count.sv
module sema_dma_count #(
  parameter int SEMA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              inc_en_i,
  input  logic [SEMA_W-1:0] inc_val_i,
  input  logic              dec_i,
  output logic [SEMA_W-1:0] count_o
);

  localparam int SW = SEMA_W + 2;
  localparam logic [SW-1:0] CMAX = SW'((1 << SEMA_W) - 1);

  logic [SEMA_W-1:0] count_q, count_d;
  logic [SW-1:0]     sum, net;
  logic              en;

  // Net update: add and decrement fold into one saturated result.
  always_comb begin
    sum = {2'b00, count_q} + (inc_en_i ? {2'b00, inc_val_i} : '0);
    if (dec_i && sum != '0) net = sum - SW'(1);
    else                    net = sum;
    if (clr_i)            count_d = '0;
    else if (net > CMAX)  count_d = CMAX[SEMA_W-1:0];
    else                  count_d = net[SEMA_W-1:0];
    en = clr_i | inc_en_i | dec_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  count_q <= '0;
    else if (en) count_q <= count_d;
  end

  assign count_o = count_q;

  AST_SEMA_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && !inc_en_i) |=> count_q == '0); // R3
  AST_SEMA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> count_q == '0); // R9
  AST_SEMA_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en_i && !dec_i && !clr_i && ({1'b0, count_q} + {1'b0, inc_val_i} <= {1'b0, CMAX[SEMA_W-1:0]}))
    |=> count_q == $past(count_q) + $past(inc_val_i)); // R4

endmodule

// File: rtl/sema_dma_fsm.sv
module sema_dma_fsm
  import sema_dma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SEMA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEMA_W-1:0] count_i,
  input  logic              gate_i,
  input  logic              abort_i,
  input  logic              sw_kick_i,
  input  logic [AW-1:0]     next_addr_i,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [AW+2:0]     mem_rdata_i,
  output logic              xfer_start_o,
  output logic [AW-1:0]     xfer_addr_o,
  input  logic              xfer_done_i,
  output logic              busy_o,
  output logic              dec_o,
  output logic              cmpl_o,
  output logic              load_o,
  output logic [AW-1:0]     load_addr_o,
  output logic              early_o
);

  localparam int DW     = AW + 3;
  localparam int LINK_B = AW;
  localparam int DEC_B  = AW + 1;
  localparam int NTF_B  = AW + 2;

  seq_state_e    state_q, state_d;
  logic          parked_q, parked_d;
  logic          start_q, start_d;
  logic [DW-1:0] desc_q, desc_d;
  logic [AW-1:0] faddr_q, faddr_d;
  logic          count_nz;

  assign count_nz = (count_i != '0);

  always_comb begin
    state_d  = state_q;
    parked_d = parked_q;
    start_d  = 1'b0;
    desc_d   = desc_q;
    faddr_d  = faddr_q;
    dec_o    = 1'b0;
    cmpl_o   = 1'b0;
    load_o   = 1'b0;
    early_o  = 1'b0;
    if (sw_kick_i) parked_d = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (count_nz && !gate_i && !parked_q) begin
          state_d = ST_FETCH;
          faddr_d = next_addr_i;
        end
      end
      ST_FETCH: begin
        if (mem_ack_i) begin
          desc_d  = mem_rdata_i;
          start_d = 1'b1;
          state_d = ST_EXEC;
        end
      end
      ST_EXEC: begin
        if (xfer_done_i) begin
          dec_o  = desc_q[DEC_B];
          cmpl_o = desc_q[NTF_B];
          load_o = desc_q[LINK_B];
          if (!desc_q[LINK_B]) begin
            parked_d = 1'b1;
            early_o  = count_i > SEMA_W'(desc_q[DEC_B]);
          end
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (abort_i) begin
      state_d  = ST_IDLE;
      parked_d = 1'b0;
      start_d  = 1'b0;
      dec_o    = 1'b0;
      cmpl_o   = 1'b0;
      load_o   = 1'b0;
      early_o  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      parked_q <= 1'b0;
      start_q  <= 1'b0;
      desc_q   <= '0;
      faddr_q  <= '0;
    end else begin
      state_q  <= state_d;
      parked_q <= parked_d;
      start_q  <= start_d;
      if (state_q == ST_FETCH && mem_ack_i) desc_q <= desc_d;
      if (state_q == ST_IDLE) faddr_q <= faddr_d;
    end
  end

  assign mem_req_o    = (state_q == ST_FETCH);
  assign mem_addr_o   = faddr_q;
  assign xfer_start_o = start_q;
  assign xfer_addr_o  = faddr_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign load_addr_o  = desc_q[AW-1:0];

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i && !abort_i) |=> mem_req_o); // R2
  AST_FETCH_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_o) |-> ($past(count_nz) && !$past(gate_i))); // R8
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start_o |=> !xfer_start_o); // R2
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !busy_o); // R9
  AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (parked_q && !busy_o && !sw_kick_i) |=> !busy_o); // R7

endmodule

// File: rtl/sema_dma_seq.sv
module sema_dma_seq #(
  parameter int AW       = 32,
  parameter int SEMA_W   = 8,
  parameter int CH_IDX   = 0,
  parameter int GATE_OFS = 8,
  parameter int RST_OFS  = 16,
  parameter int IEN_OFS  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [1:0]    reg_op,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [AW+2:0] mem_rdata,
  output logic          xfer_start,
  output logic [AW-1:0] xfer_addr,
  input  logic          xfer_done,
  output logic          chan_busy,
  output logic          irq
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic [SEMA_W-1:0] count;
  logic              gate, abort, next_wr, inc_en;
  logic [SEMA_W-1:0] inc_val;
  logic [AW-1:0]     next_addr, load_addr;
  logic              dec, cmpl, load, early;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  sema_dma_regs #(
    .AW(AW), .SEMA_W(SEMA_W), .CH_IDX(CH_IDX),
    .GATE_OFS(GATE_OFS), .RST_OFS(RST_OFS), .IEN_OFS(IEN_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_i),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_op(reg_op),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hw_cmpl_i(cmpl), .hw_early_i(early), .hw_load_i(load),
    .hw_next_i(load_addr), .count_i(count),
    .gate_o(gate), .abort_o(abort), .next_addr_o(next_addr),
    .next_wr_o(next_wr), .inc_en_o(inc_en), .inc_val_o(inc_val),
    .irq_o(irq)
  );

  sema_dma_count #(.SEMA_W(SEMA_W)) u_count (
    .clk(clk), .rst_n(rst_n_i),
    .clr_i(abort), .inc_en_i(inc_en), .inc_val_i(inc_val),
    .dec_i(dec), .count_o(count)
  );

  sema_dma_fsm #(.AW(AW), .SEMA_W(SEMA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_i),
    .count_i(count), .gate_i(gate), .abort_i(abort),
    .sw_kick_i(next_wr | inc_en), .next_addr_i(next_addr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .xfer_start_o(xfer_start), .xfer_addr_o(xfer_addr),
    .xfer_done_i(xfer_done), .busy_o(chan_busy),
    .dec_o(dec), .cmpl_o(cmpl), .load_o(load),
    .load_addr_o(load_addr), .early_o(early)
  );

endmodule

// File: tb/sema_dma_seq_bench.sv
module sema_dma_seq_bench;

  localparam int AW = 32;
  localparam int DONE_LAT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_sel = 3'd0;
  logic [1:0]    reg_op = 2'd0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_ack = 1'b0;
  logic [AW+2:0] mem_rdata = '0;
  logic          xfer_start;
  logic [AW-1:0] xfer_addr;
  logic          xfer_done = 1'b0;
  logic          chan_busy;
  logic          irq;

  logic [AW+2:0] tbl [16];
  int            exec_log [64];
  int            exec_n = 0;
  int            wait_cnt = 0;
  bit            hold_done = 1'b0;
  int            n_checks = 0;
  int            n_fail = 0;
  bit            finished = 1'b0;

  sema_dma_seq u_sema_dma_seq (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_op(reg_op),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .xfer_start(xfer_start), .xfer_addr(xfer_addr),
    .xfer_done(xfer_done), .chan_busy(chan_busy), .irq(irq)
  );

  initial forever #4 clk = ~clk;

  function automatic logic [AW+2:0] mk(int nxt, bit link, bit dec, bit ntf);
    return {ntf, dec, link, AW'(nxt)};
  endfunction

  // Memory and data-mover models.
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        mem_rdata = tbl[mem_addr[3:0]];
        mem_ack = 1'b1;
      end
      if (xfer_done) xfer_done = 1'b0;
      if (xfer_start) begin
        if (exec_n < 64) exec_log[exec_n] = int'(xfer_addr);
        exec_n++;
        wait_cnt = DONE_LAT;
      end else if (wait_cnt > 0 && !hold_done) begin
        wait_cnt--;
        if (wait_cnt == 0) xfer_done = 1'b1;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] sel, logic [1:0] op, logic [31:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_op = op; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] sel, output logic [31:0] v);
    @(negedge clk);
    reg_sel = sel;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    int guard = 0;
    while (quiet < 4 && guard < 3000) begin
      @(negedge clk);
      if (!chan_busy) quiet++;
      else quiet = 0;
      guard++;
    end
  endtask

  task automatic idle_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_read(3'd0, v); check(v == 32'h100, "R1", "ctrl0 after reset", v, 32'h100);
    reg_read(3'd1, v); check(v == 0, "R1", "ctrl1 after reset", v, 0);
    reg_read(3'd2, v); check(v == 0, "R1", "ctrl2 after reset", v, 0);
    reg_read(3'd3, v); check(v == 0, "R1", "next address after reset", v, 0);
    reg_read(3'd4, v); check(v == 0, "R1", "run count after reset", v, 0);
    check(!chan_busy && !irq, "R1", "busy/irq after reset", {chan_busy, irq}, 0);
  endtask

  task automatic t_hold_and_notify();
    logic [31:0] v;
    tbl[1] = mk(0, 0, 1, 1);
    reg_write(3'd3, 2'd0, 1);
    reg_write(3'd4, 2'd0, 1);
    idle_cycles(10);
    check(exec_n == 0, "R8", "no command while held", exec_n, 0);
    reg_read(3'd4, v); check(v == 1, "R8", "count kept while held", v, 1);
    reg_write(3'd0, 2'd2, 32'h100);
    reg_read(3'd0, v); check(v == 0, "R11", "hold cleared by clear alias", v, 0);
    wait_idle();
    check(exec_n == 1 && exec_log[0] == 1, "R2", "first command address", exec_log[0], 1);
    reg_read(3'd4, v); check(v == 0, "R6", "count after single command", v, 0);
    reg_read(3'd1, v); check(v == 1, "R10", "completion status", v, 1);
    check(!irq, "R10", "irq masked", irq, 0);
    reg_write(3'd1, 2'd1, 32'h1_0000);
    @(negedge clk);
    check(irq, "R10", "irq with enable", irq, 1);
    reg_write(3'd1, 2'd2, 1);
    reg_write(3'd2, 2'd2, 1);
    @(negedge clk);
    check(!irq, "R11", "irq after acknowledge", irq, 0);
    reg_read(3'd1, v); check(v == 32'h1_0000, "R11", "ctrl1 after acknowledge", v, 32'h1_0000);
    reg_write(3'd4, 2'd0, 0);
    idle_cycles(10);
    check(exec_n == 1, "R2", "zero count starts nothing", exec_n, 1);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    int base = exec_n;
    tbl[2] = mk(5, 1, 1, 0);
    tbl[5] = mk(7, 1, 1, 0);
    tbl[7] = mk(3, 1, 1, 0);
    reg_write(3'd3, 2'd0, 2);
    reg_write(3'd4, 2'd0, 3);
    wait_idle();
    check(exec_n - base == 3, "R6", "commands in linked run", exec_n - base, 3);
    check(exec_log[base+1] == 5 && exec_log[base+2] == 7, "R5", "link order",
          {exec_log[base+1], exec_log[base+2]}, {32'd5, 32'd7});
    reg_read(3'd3, v); check(v == 3, "R5", "next address follows link", v, 3);
    reg_read(3'd4, v); check(v == 0, "R6", "count exhausted", v, 0);
  endtask

  task automatic t_nodec();
    logic [31:0] v;
    int base = exec_n;
    tbl[8] = mk(9, 1, 0, 0);
    tbl[9] = mk(0, 0, 1, 0);
    reg_write(3'd3, 2'd0, 8);
    reg_write(3'd4, 2'd0, 1);
    wait_idle();
    check(exec_n - base == 2, "R3", "non-decrementing command keeps run", exec_n - base, 2);
    reg_read(3'd4, v); check(v == 0, "R3", "count after run", v, 0);
    reg_read(3'd2, v); check(v == 0, "R7", "no early-end status", v, 0);
  endtask

  task automatic t_early_end();
    logic [31:0] v;
    int base = exec_n;
    tbl[10] = mk(0, 0, 1, 0);
    tbl[11] = mk(0, 0, 1, 0);
    reg_write(3'd3, 2'd0, 10);
    reg_write(3'd4, 2'd0, 3);
    wait_idle();
    idle_cycles(10);
    check(exec_n - base == 1, "R7", "idle after unlinked command", exec_n - base, 1);
    reg_read(3'd4, v); check(v == 2, "R7", "count left over", v, 2);
    reg_read(3'd2, v); check(v == 1, "R7", "early-end status", v, 1);
    reg_write(3'd3, 2'd0, 11);
    wait_idle();
    check(exec_n - base == 2 && exec_log[base+1] == 11, "R7", "restart by address write",
          exec_log[base+1], 11);
    reg_write(3'd4, 2'd0, 0);
    wait_idle();
    check(exec_n - base == 3 && exec_log[base+2] == 11, "R7", "restart by count write",
          exec_n - base, 3);
    reg_read(3'd4, v); check(v == 0, "R7", "count after restarts", v, 0);
    reg_write(3'd2, 2'd2, 1);
    reg_read(3'd2, v); check(v == 0, "R11", "early-end acknowledge", v, 0);
  endtask

  task automatic t_extend();
    logic [31:0] v;
    int base = exec_n;
    int guard = 0;
    tbl[12] = mk(13, 1, 1, 0);
    tbl[13] = mk(14, 1, 1, 0);
    tbl[14] = mk(15, 1, 1, 0);
    tbl[15] = mk(0, 0, 1, 0);
    reg_write(3'd3, 2'd0, 12);
    reg_write(3'd4, 2'd0, 1);
    while (exec_n == base && guard < 200) begin @(negedge clk); guard++; end
    reg_write(3'd4, 2'd0, 3);
    wait_idle();
    check(exec_n - base == 4, "R4", "run extended by add", exec_n - base, 4);
    check(exec_log[base+3] == 15, "R5", "last linked address", exec_log[base+3], 15);
    reg_read(3'd4, v); check(v == 0, "R4", "net count after extension", v, 0);
  endtask

  task automatic t_saturate_reset();
    logic [31:0] v;
    reg_write(3'd0, 2'd1, 32'h100);
    reg_read(3'd0, v); check(v == 32'h100, "R11", "hold set by set alias", v, 32'h100);
    reg_write(3'd4, 2'd0, 200);
    reg_write(3'd4, 2'd0, 100);
    reg_read(3'd4, v); check(v == 255, "R4", "count saturates", v, 255);
    reg_write(3'd4, 2'd1, 0);
    reg_write(3'd4, 2'd2, 32'hFF);
    reg_read(3'd4, v); check(v == 255, "R12", "set/clear alias on count ignored", v, 255);
    reg_write(3'd0, 2'd1, 32'h1_0000);
    reg_read(3'd4, v); check(v == 0, "R9", "abort clears count", v, 0);
    reg_read(3'd0, v); check(v == 32'h100, "R9", "abort bit self-clears", v, 32'h100);
    reg_write(3'd0, 2'd0, 0);
    reg_read(3'd0, v); check(v == 0, "R11", "plain write replaces ctrl0", v, 0);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    int base = exec_n;
    int guard = 0;
    tbl[4] = mk(0, 0, 1, 0);
    hold_done = 1'b1;
    reg_write(3'd3, 2'd0, 4);
    reg_write(3'd4, 2'd0, 2);
    while (exec_n == base && guard < 200) begin @(negedge clk); guard++; end
    check(chan_busy, "R9", "busy mid-command", chan_busy, 1);
    reg_write(3'd0, 2'd1, 32'h1_0000);
    check(!chan_busy, "R9", "idle after abort", chan_busy, 0);
    reg_read(3'd4, v); check(v == 0, "R9", "count after abort", v, 0);
    hold_done = 1'b0;
    idle_cycles(12);
    check(exec_n - base == 1 && !chan_busy, "R9", "no further command", exec_n - base, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) tbl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_hold_and_notify();
    t_chain();
    t_nodec();
    t_early_end();
    t_extend();
    t_saturate_reset();
    t_abort();
    finish_run();
  end

endmodule